// File: doc/BRIEF.md
# Absolute-Difference Signature Accumulator

This block builds a running test signature from a loopback experiment on a mixed-signal path. Every cycle the test controller enables it, the block takes the stimulus word that was sent toward the DAC and the word that came back from the ADC. It derives one term from them and adds that term into a split accumulator. The accumulator has a low half and a high half of equal width, joined by a carry. Both halves are output so that a processor can read the final sum and judge pass or fail against a window of acceptable values.

Three term sources can be selected. The first sums the stimulus alone, which tests the digital logic without the analog path. The second sums the ADC samples. The third sums the absolute difference between stimulus and response, which reacts to noise and phase shift. The stimulus and ADC widths may differ. The narrower word is aligned to the most significant bit of the wider one before use, so both words share one full-scale range. A start pulse clears the signature. If the sum outgrows both halves, the accumulator saturates and a sticky flag marks the overflow.

Top module: `absdiff_sigacc`

## Requirements
- R1: After reset is released, `accLow`, `accHigh` and `overflow` are all zero.
- R2: A cycle with `start` high clears both halves and `overflow` at the next clock edge. In that cycle nothing is added, even when `enable` is high.
- R3: A cycle with `enable` low and `start` low leaves both halves and `overflow` unchanged.
- R4: With `mode` = 0, an enabled cycle adds the stimulus word, aligned to the MSB of the wider input width.
- R5: With `mode` = 1, an enabled cycle adds the ADC word, aligned to the MSB. With the default widths (stimulus 8 bits, ADC 6 bits), the ADC word is shifted left by 2.
- R6: With `mode` = 2 or `mode` = 3, an enabled cycle adds |aligned stimulus − aligned ADC word|.
- R7: When the low-half sum produces a carry out of `ACC_W` bits, the low half keeps the wrapped value and the high half increments by one.
- R8: If a carry arrives while the high half is all ones, both halves become all ones and `overflow` is set. Further enabled cycles change nothing until the next `start`.
- R9: An enabled cycle's term appears on the outputs right after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the signature and the overflow flag |
| enable | input | 1 | Adds one term when high |
| mode | input | 2 | Term select: 0 stimulus, 1 ADC, 2 or 3 absolute difference |
| stimWord | input | DAC_W | Stimulus word sent toward the DAC |
| adcWord | input | ADC_W | Response word captured from the ADC |
| accLow | output | ACC_W | Low half of the signature |
| accHigh | output | ACC_W | High half of the signature |
| overflow | output | 1 | Sticky saturation flag |

## Verification
The stimulus-sum mode is driven with a short run whose total crosses 256. This separates the wrapped low half from the carried high half. ADC sums at full scale reveal the MSB alignment, because a missing shift gives a sum four times too small. Difference sums use stimulus above and below the response, so a plain or sign-losing subtraction shows up. A long full-scale run walks the high half to all ones and past it, which checks saturation, that further adds are ignored, and that start releases the flag.

// File: rtl/sigacc_pkg.sv
package sigacc_pkg;
  typedef enum logic [1:0] {
    TERM_STIM = 2'd0,
    TERM_ADC  = 2'd1,
    TERM_DIFF = 2'd2,
    TERM_DIF2 = 2'd3
  } term_sel_e;

  typedef struct packed {
    logic clr;
    logic add;
  } acc_strobe_t;
endpackage

// File: rtl/sigacc_ctrl.sv
module sigacc_ctrl
  import sigacc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        enable,
  output acc_strobe_t strobes
);
  always_comb begin
    strobes.clr = start;
    strobes.add = enable & ~start;
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.clr, strobes.add}));
endmodule

// File: rtl/sigacc_dp.sv
module sigacc_dp
  import sigacc_pkg::*;
#(
  parameter int DAC_W = 8,
  parameter int ADC_W = 6,
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_strobe_t      strobes,
  input  logic [1:0]       mode,
  input  logic [DAC_W-1:0] stimWord,
  input  logic [ADC_W-1:0] adcWord,
  output logic [ACC_W-1:0] accLow,
  output logic [ACC_W-1:0] accHigh,
  output logic             overflow
);
  localparam int MAX_W = (DAC_W > ADC_W) ? DAC_W : ADC_W;
  localparam int STIM_SH = MAX_W - DAC_W;
  localparam int ADC_SH  = MAX_W - ADC_W;

  logic [MAX_W-1:0] stimAl, adcAl, absDiff, term;
  logic [ACC_W:0]   lowSum;
  logic             carry, hiFull;

  assign stimAl = MAX_W'(stimWord) << STIM_SH;
  assign adcAl  = MAX_W'(adcWord) << ADC_SH;
  assign absDiff = (stimAl >= adcAl) ? (stimAl - adcAl) : (adcAl - stimAl);

  always_comb begin
    unique case (term_sel_e'(mode))
      TERM_STIM: term = stimAl;
      TERM_ADC:  term = adcAl;
      default:   term = absDiff;
    endcase
  end

  assign lowSum = {1'b0, accLow} + (ACC_W+1)'(term);
  assign carry  = lowSum[ACC_W];
  assign hiFull = &accHigh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accLow   <= '0;
      accHigh  <= '0;
      overflow <= 1'b0;
    end else if (strobes.clr) begin
      accLow   <= '0;
      accHigh  <= '0;
      overflow <= 1'b0;
    end else if (strobes.add && !overflow) begin
      if (carry && hiFull) begin
        accLow   <= '1;
        accHigh  <= '1;
        overflow <= 1'b1;
      end else begin
        accLow  <= lowSum[ACC_W-1:0];
        accHigh <= accHigh + ACC_W'(carry);
      end
    end
  end

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clr |=> (accLow == '0 && accHigh == '0 && !overflow));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.clr && !strobes.add) |=> ($stable(accLow) && $stable(accHigh) && $stable(overflow)));
  // R7
  high_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.clr |=> (accHigh >= $past(accHigh)));
  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !strobes.clr) |=> overflow);
  // R8
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (&accHigh && &accLow));
endmodule

// File: rtl/absdiff_sigacc.sv
module absdiff_sigacc
  import sigacc_pkg::*;
#(
  parameter int DAC_W = 8,
  parameter int ADC_W = 6,
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic [DAC_W-1:0] stimWord,
  input  logic [ADC_W-1:0] adcWord,
  output logic [ACC_W-1:0] accLow,
  output logic [ACC_W-1:0] accHigh,
  output logic             overflow
);
  acc_strobe_t strobes;

  sigacc_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable), .strobes(strobes)
  );

  sigacc_dp #(.DAC_W(DAC_W), .ADC_W(ADC_W), .ACC_W(ACC_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .mode(mode),
    .stimWord(stimWord), .adcWord(adcWord),
    .accLow(accLow), .accHigh(accHigh), .overflow(overflow)
  );
endmodule

// File: tb/test_absdiff_sigacc.sv
module test_absdiff_sigacc;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] stimWord = '0;
  logic [5:0] adcWord = '0;
  logic [7:0] accLow, accHigh;
  logic       overflow;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  absdiff_sigacc i_absdiff_sigacc (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable), .mode(mode),
    .stimWord(stimWord), .adcWord(adcWord),
    .accLow(accLow), .accHigh(accHigh), .overflow(overflow)
  );

  task automatic check(string req, int lo, int hi, bit ov);
    checks++;
    if (accLow !== lo[7:0] || accHigh !== hi[7:0] || overflow !== ov) begin
      errors++;
      $display("FAIL %s: got low=%0d high=%0d ovf=%0b, expected low=%0d high=%0d ovf=%0b",
               req, accLow, accHigh, overflow, lo, hi, ov);
    end
  endtask

  // drive at negedge; sampled at the next posedge; outputs readable at the following negedge
  task automatic push(bit st, bit en, logic [1:0] md, logic [7:0] s, logic [5:0] a);
    start = st; enable = en; mode = md; stimWord = s; adcWord = a;
    @(negedge clk);
    start = 1'b0; enable = 1'b0;
  endtask

  task automatic clear_acc();
    push(1, 1, 2'd0, 8'd99, 6'd0);
  endtask

  task automatic t_reset();
    check("R1 reset", 0, 0, 0);
  endtask

  task automatic t_stim_carry();
    clear_acc();
    check("R2 start clears, ignores enable", 0, 0, 0);
    push(0, 1, 2'd0, 8'd10, 6'd63);
    check("R9 term visible after one edge", 10, 0, 0);
    push(0, 1, 2'd0, 8'd20, 6'd63);
    push(0, 1, 2'd0, 8'd200, 6'd63);
    check("R4 stimulus sum", 230, 0, 0);
    push(0, 1, 2'd0, 8'd100, 6'd0);
    check("R7 carry into high half", 74, 1, 0);
  endtask

  task automatic t_hold();
    push(0, 0, 2'd0, 8'd255, 6'd63);
    push(0, 0, 2'd2, 8'd0, 6'd63);
    check("R3 enable low holds", 74, 1, 0);
  endtask

  task automatic t_adc();
    clear_acc();
    for (int i = 0; i < 3; i++) push(0, 1, 2'd1, 8'd0, 6'd63);
    check("R5 ADC sum MSB aligned", 244, 2, 0);
  endtask

  task automatic t_diff();
    clear_acc();
    push(0, 1, 2'd2, 8'd100, 6'd20);
    check("R6 diff stim above", 20, 0, 0);
    push(0, 1, 2'd2, 8'd10, 6'd20);
    check("R6 diff stim below", 90, 0, 0);
    push(0, 1, 2'd3, 8'd0, 6'd63);
    check("R6 mode 3 acts as diff", 86, 1, 0);
  endtask

  task automatic t_overflow();
    clear_acc();
    for (int i = 0; i < 260; i++) push(0, 1, 2'd1, 8'd0, 6'd63);
    check("R7 high reaches all ones", 240, 255, 0);
    push(0, 1, 2'd1, 8'd0, 6'd63);
    check("R8 saturate and flag", 255, 255, 1);
    push(0, 1, 2'd0, 8'd5, 6'd0);
    check("R8 further adds ignored", 255, 255, 1);
    clear_acc();
    check("R2 start clears overflow", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stim_carry();
    t_hold();
    t_adc();
    t_diff();
    t_overflow();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule